// File: doc/BRIEF.md
# Storage Display Erase Sequencer

This block turns the mode pushbuttons of a storage display into a decoded write-mode flag. While write mode is active, it runs the timed erase schedule for the tube's mesh electrode. A free-running millisecond tick paces everything. Releasing the erase button starts the schedule, and that instant is time zero. The schedule then drives three phases in turn: a large positive erase level, a near-zero level, and a second erase level. After that it hands over to a repeating dynamic erase pulse with a 100 Hz period and a duty cycle set by the persistence input.

The mesh drive choice comes out as a registered one-hot selector. The analog stage behind it maps each selector bit to a voltage. A separate enable switches the background-adjust path in only when the persistence control sits at its maximum position. If write mode is left at any point, the schedule is abandoned and the selector drops to idle.

Top module: `erase_seq_top`

## Requirements
- R1: `write_mode_o` is high exactly when `wr_btn_ni` is 0 and both `fast_btn_ni` and `store_btn_ni` are 1; it follows the buttons combinationally.
- R2: `mesh_sel_o` is one-hot and registered. It reflects the state one clock after the state changes. Bit 0 is idle, bit 1 is the first erase level, bit 2 is the near-zero level, bit 3 is the second erase level, and bit 4 is the dynamic erase pulse.
- R3: A schedule starts only on a 0-to-1 transition of `erase_btn_ni` while in write mode. Pressing or holding erase, or releasing it outside write mode, starts nothing.
- R4: From a release until 100 ticks later, the selector shows the first erase level.
- R5: From tick 100 to tick 599 after the release, the selector shows the near-zero level.
- R6: From tick 600 to tick 1199 after the release, the selector shows the second erase level.
- R7: From tick 1200 onward, the dynamic pulse phase counter counts ticks modulo 10, starting at 0 from reset. The selector shows the pulse (bit 4) when the phase is below `persist_i[7:6]` and shows idle otherwise. This gives 0 to 3 high ticks per 10, or at most 30%.
- R8: When `persist_i[7:6]` is 0, the dynamic pulse is never selected.
- R9: A release while the dynamic pulses run, or while the schedule runs, restarts the full 1200-tick schedule from the first erase level.
- R10: Leaving write mode forces idle on the next clock and abandons the schedule. Re-entering write mode without a release goes straight to dynamic pulses.
- R11: `bg_adj_en_o` is high exactly when `persist_max_i` is high.
- R12: While `rst_ni` is low, the selector is idle, the schedule is complete and the pulse phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per millisecond |
| wr_btn_ni | input | 1 | Write button, active low |
| fast_btn_ni | input | 1 | Fast button, active low |
| store_btn_ni | input | 1 | Store button, active low |
| erase_btn_ni | input | 1 | Erase button, active low |
| persist_i | input | 8 | Persistence setting |
| persist_max_i | input | 1 | Persistence control at maximum |
| write_mode_o | output | 1 | Decoded write mode |
| mesh_sel_o | output | 5 | One-hot mesh drive selector |
| bg_adj_en_o | output | 1 | Background-adjust path enable |

## Verification
The assertions assume the buttons are already debounced and synchronous to `clk_i`. They also assume the erase button is held released during reset, so a release edge seen just after reset is a real edge. Ticks are taken to be single-cycle pulses separated by idle cycles. The stimulus keeps to these assumptions: every button and setting changes on the falling clock edge, and erase sits at 1 across every reset. Ticks are issued one clock high followed by one clock low. No tick coincides with a release, so the cycle in which each phase boundary appears is fixed.

// File: rtl/erase_seq_pkg.sv
`timescale 1ns/1ps
package erase_seq_pkg;
  localparam int SEL_W = 5;
  typedef enum logic [SEL_W-1:0] {
    SEL_IDLE   = 5'b00001,
    SEL_ERASE1 = 5'b00010,
    SEL_ZERO   = 5'b00100,
    SEL_ERASE2 = 5'b01000,
    SEL_DYN    = 5'b10000
  } mesh_sel_e;
endpackage

// File: rtl/erase_btn_decode.sv
`timescale 1ns/1ps
module erase_btn_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  input  logic fast_ni,
  input  logic store_ni,
  input  logic erase_ni,
  output logic write_mode_o,
  output logic erase_rel_o
);
  logic erase_q;

  assign write_mode_o = ~wr_ni & fast_ni & store_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) erase_q <= 1'b1;
    else         erase_q <= erase_ni;
  end

  // release = low-to-high on the active-low button
  assign erase_rel_o = erase_ni & ~erase_q;
endmodule

// File: rtl/erase_sched_timer.sv
`timescale 1ns/1ps
module erase_sched_timer #(
  parameter int E1_END   = 100,
  parameter int ZERO_END = 600,
  parameter int E2_END   = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic write_i,
  input  logic start_i,
  output logic in_e1_o,
  output logic in_zero_o,
  output logic in_e2_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(E2_END + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(E2_END);

  logic [CNT_W-1:0] ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ms_q <= CNT_DONE;
    else if (!write_i)                   ms_q <= CNT_DONE;
    else if (start_i)                    ms_q <= '0;
    else if (tick_i && ms_q != CNT_DONE) ms_q <= ms_q + 1'b1;
  end

  assign done_o    = (ms_q == CNT_DONE);
  assign in_e1_o   = (ms_q < CNT_W'(E1_END));
  assign in_zero_o = !in_e1_o && (ms_q < CNT_W'(ZERO_END));
  assign in_e2_o   = !in_e1_o && !in_zero_o && !done_o;
endmodule

// File: rtl/erase_dyn_pulse.sv
`timescale 1ns/1ps
module erase_dyn_pulse #(
  parameter int PERIOD    = 10,
  parameter int PERSIST_W = 8,
  parameter int MAX_HIGH  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [PERSIST_W-1:0] persist_i,
  output logic                 pulse_o
);
  localparam int PH_W = $clog2(PERIOD);
  localparam int HI_W = $clog2(MAX_HIGH + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q;
  logic [HI_W-1:0] hi_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (tick_i) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  // linear map: top bits of the setting give the high ticks
  assign hi_ticks = persist_i[PERSIST_W-1 -: HI_W];
  assign pulse_o  = ({{(PH_W > HI_W ? PH_W - HI_W : 0){1'b0}}, hi_ticks} > ph_q);
endmodule

// File: rtl/erase_seq_top.sv
`timescale 1ns/1ps
module erase_seq_top
  import erase_seq_pkg::*;
#(
  parameter int PERSIST_W = 8,
  parameter int E1_END    = 100,
  parameter int ZERO_END  = 600,
  parameter int E2_END    = 1200,
  parameter int PERIOD    = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_btn_ni,
  input  logic                 fast_btn_ni,
  input  logic                 store_btn_ni,
  input  logic                 erase_btn_ni,
  input  logic [PERSIST_W-1:0] persist_i,
  input  logic                 persist_max_i,
  output logic                 write_mode_o,
  output logic [SEL_W-1:0]     mesh_sel_o,
  output logic                 bg_adj_en_o
);
  logic erase_rel, in_e1, in_zero, in_e2, done, pulse;
  mesh_sel_e sel_d, sel_q;

  erase_btn_decode u_dec (
    .clk_i, .rst_ni,
    .wr_ni(wr_btn_ni), .fast_ni(fast_btn_ni), .store_ni(store_btn_ni),
    .erase_ni(erase_btn_ni),
    .write_mode_o(write_mode_o), .erase_rel_o(erase_rel)
  );

  erase_sched_timer #(.E1_END(E1_END), .ZERO_END(ZERO_END), .E2_END(E2_END)) u_tmr (
    .clk_i, .rst_ni, .tick_i,
    .write_i(write_mode_o), .start_i(erase_rel),
    .in_e1_o(in_e1), .in_zero_o(in_zero), .in_e2_o(in_e2), .done_o(done)
  );

  erase_dyn_pulse #(.PERIOD(PERIOD), .PERSIST_W(PERSIST_W), .MAX_HIGH(PERIOD * 3 / 10)) u_dyn (
    .clk_i, .rst_ni, .tick_i, .persist_i, .pulse_o(pulse)
  );

  always_comb begin
    sel_d = SEL_IDLE;
    if (write_mode_o) begin
      if (in_e1)                 sel_d = SEL_ERASE1;
      else if (in_zero)          sel_d = SEL_ZERO;
      else if (in_e2)            sel_d = SEL_ERASE2;
      else if (done && pulse)    sel_d = SEL_DYN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_IDLE;
    else         sel_q <= sel_d;
  end

  assign mesh_sel_o  = sel_q;
  assign bg_adj_en_o = persist_max_i;
endmodule

// File: rtl/erase_seq_chk.sv
`timescale 1ns/1ps
module erase_seq_chk
  import erase_seq_pkg::*;
#(
  parameter int PERSIST_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 erase_btn_ni,
  input logic [PERSIST_W-1:0] persist_i,
  input logic                 write_mode_o,
  input logic [SEL_W-1:0]     mesh_sel_o
);
  a_r2_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mesh_sel_o) == 1);

  a_r10_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_mode_o |=> mesh_sel_o == SEL_IDLE);

  a_r3_release_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_mode_o && $rose(erase_btn_ni)) |-> ##2 (mesh_sel_o == SEL_ERASE1 || !$past(write_mode_o)));

  a_r4_erase1_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mesh_sel_o == SEL_ERASE1 |=>
      (mesh_sel_o == SEL_ERASE1 || mesh_sel_o == SEL_ZERO || mesh_sel_o == SEL_IDLE));

  a_r5_zero_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mesh_sel_o == SEL_ZERO |=>
      (mesh_sel_o == SEL_ZERO || mesh_sel_o == SEL_ERASE2 ||
       mesh_sel_o == SEL_IDLE || mesh_sel_o == SEL_ERASE1));

  a_r6_erase2_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mesh_sel_o == SEL_ERASE2 |=> mesh_sel_o != SEL_ZERO);

  a_r8_no_pulse_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (persist_i[PERSIST_W-1 -: 2] == 2'b00) |=> mesh_sel_o != SEL_DYN);
endmodule

bind erase_seq_top erase_seq_chk #(.PERSIST_W(PERSIST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .erase_btn_ni(erase_btn_ni),
  .persist_i(persist_i), .write_mode_o(write_mode_o), .mesh_sel_o(mesh_sel_o)
);

// File: tb/erase_seq_top_bench.sv
`timescale 1ns/1ps
module erase_seq_top_bench;
  localparam logic [4:0] S_IDLE = 5'b00001, S_E1 = 5'b00010, S_ZERO = 5'b00100,
                         S_E2 = 5'b01000, S_DYN = 5'b10000, S_CALC = 5'b00000;

  // schedule walk: ticks to issue, then expected selector (S_CALC = dynamic)
  localparam int unsigned STEP_TICKS [0:6] = '{0, 99, 1, 499, 1, 599, 1};
  localparam logic [4:0]  STEP_SEL   [0:6] = '{S_E1, S_E1, S_ZERO, S_ZERO, S_E2, S_E2, S_CALC};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_n = 1'b1, fast_n = 1'b1, store_n = 1'b1, erase_n = 1'b1;
  logic [7:0] persist = 8'h00;
  logic pmax = 1'b0;
  logic write_mode, bg_en;
  logic [4:0] sel;
  int checks = 0, errors = 0, total_ticks = 0;

  always #4 clk = ~clk;

  erase_seq_top u_erase_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_btn_ni(wr_n), .fast_btn_ni(fast_n), .store_btn_ni(store_n),
    .erase_btn_ni(erase_n), .persist_i(persist), .persist_max_i(pmax),
    .write_mode_o(write_mode), .mesh_sel_o(sel), .bg_adj_en_o(bg_en)
  );

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [4:0] dyn_exp();
    return ((total_ticks % 10) < int'(persist[7:6])) ? S_DYN : S_IDLE;
  endfunction

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_ticks(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      total_ticks++;
    end
    @(negedge clk);
  endtask

  task automatic release_erase();
    @(negedge clk) erase_n = 1'b0;
    @(negedge clk) erase_n = 1'b1;
    settle();
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset selector", sel, S_IDLE);
    check("R1 no write at reset", {4'b0, write_mode}, 5'b0);
    check("R11 bg off", {4'b0, bg_en}, 5'b0);
    rst_n = 1'b1;
    settle();

    wr_n = 1'b0; #1;
    check("R1 write decoded", {4'b0, write_mode}, 5'b1);
    settle();
    check("R8 zero persist idle", sel, S_IDLE);
    fast_n = 1'b0; #1;
    check("R1 fast blocks write", {4'b0, write_mode}, 5'b0);
    fast_n = 1'b1; store_n = 1'b0; #1;
    check("R1 store blocks write", {4'b0, write_mode}, 5'b0);
    store_n = 1'b1;
    persist = 8'hC8;
    settle();

    // table walk through the schedule
    release_erase();
    for (int k = 0; k < 7; k++) begin
      do_ticks(STEP_TICKS[k]);
      check("R4 R5 R6 R7 schedule step", sel, (STEP_SEL[k] == S_CALC) ? dyn_exp() : STEP_SEL[k]);
    end

    for (int k = 0; k < 10; k++) begin do_ticks(1); check("R7 duty 3", sel, dyn_exp()); end
    persist = 8'h40; settle();
    for (int k = 0; k < 10; k++) begin do_ticks(1); check("R7 duty 1", sel, dyn_exp()); end
    persist = 8'h3F; settle();
    for (int k = 0; k < 10; k++) begin do_ticks(1); check("R8 no pulse", sel, S_IDLE); end

    // holding erase starts nothing
    persist = 8'hFF;
    @(negedge clk) erase_n = 1'b0;
    do_ticks(5);
    check("R3 press ignored", sel, dyn_exp());
    @(negedge clk) erase_n = 1'b1;
    settle();
    check("R9 restart from pulses", sel, S_E1);
    do_ticks(150);
    check("R5 zero level", sel, S_ZERO);
    release_erase();
    check("R9 restart mid schedule", sel, S_E1);

    wr_n = 1'b1; settle();
    check("R10 abort idle", sel, S_IDLE);
    release_erase();
    do_ticks(3);
    check("R3 release outside write", sel, S_IDLE);
    wr_n = 1'b0; settle();
    check("R10 reenter dynamic", sel, dyn_exp());

    release_erase();
    do_ticks(700);
    check("R6 second erase", sel, S_E2);
    wr_n = 1'b1; settle();
    check("R10 abort from erase2", sel, S_IDLE);
    wr_n = 1'b0; settle();
    check("R10 no resume of schedule", sel, dyn_exp());

    pmax = 1'b1; #1;
    check("R11 bg on", {4'b0, bg_en}, 5'b1);

    release_erase();
    do_ticks(10);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R12 reset mid schedule", sel, S_IDLE);
    total_ticks = 0;
    @(negedge clk) rst_n = 1'b1;
    settle();
    check("R12 schedule done after reset", sel, dyn_exp());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule